// File: doc/BRIEF.md
# Serial Flash Write-Permission Command Front End

This block sits at the input of a serial-flash slave and decides whether the device may be written. It oversamples the serial clock, chip-select and serial-data pins with the core clock, shifts opcode bits in MSB first on rising serial-clock edges while chip-select is low, and acts on a frame only at the moment chip-select returns high, and only if the frame had the exact number of clock pulses its opcode needs.

It keeps three pieces of state. The first is a write-permission latch, which drives the grant that program, erase and status-write engines must check. The second is an auto-increment mode flag. The third is a one-shot arm flag that makes the next command a legal status-register write. A simple status-register write (four protection bits) is included so that the arm rule can be exercised. A completion pulse from the program/erase engine removes the write permission. The serial output is never driven by any command this block handles.

Top module: `spif_wr_ctrl`

## Requirements
- R1: A frame of exactly 8 clocks carrying opcode 0x06 sets the write-permission latch, shown as status bit 1 and on `wr_grant`.
- R2: A frame of exactly 8 clocks carrying opcode 0x04 clears both the write-permission latch (status bit 1) and the auto-increment flag (status bit 6).
- R3: `wr_grant` is high only while the write-permission latch is set, and a `pe_done` pulse clears the latch so that the grant is low from the next cycle.
- R4: A frame whose clock count differs from its required length (16 for opcode 0x01, 8 for every other opcode) is ignored: status, grant and arm state are unchanged.
- R5: Opcode 0x50 (8 clocks) arms the status write. A following frame of 16 clocks with opcode 0x01 and a data byte copies data bits 5..2 into status bits 5..2 and clears the write-permission latch.
- R6: The arm lasts for one command only: any other valid frame in between discards it, and a 0x01 frame that is not armed changes nothing.
- R7: Bits are taken MSB first on rising serial-clock edges, and frames are accepted whether the clock idles low (mode 0) or high (mode 3).
- R8: The serial output enable `spi_so_oe` stays low at all times.
- R9: Opcode 0xAF (8 clocks) sets the auto-increment flag (status bit 6) only while the write-permission latch is set; otherwise it has no effect.
- R10: After reset the status byte is 0x00 and `wr_grant` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock used to oversample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock pin |
| spi_cs_n | input | 1 | Chip-select pin, active low |
| spi_si | input | 1 | Serial data in |
| spi_so | output | 1 | Serial data out value (unused by these commands) |
| spi_so_oe | output | 1 | Serial data out enable, always low |
| pe_done | input | 1 | Pulse from the program/erase engine when an operation completes |
| wr_grant | output | 1 | Write permission for program, erase and status-write engines |
| status | output | 8 | Status byte: bit 6 auto-increment, bits 5..2 protection, bit 1 write permission |

## Verification
Directed frames cover each opcode at its right length in both clock modes, the arm followed at once by a status write versus the arm broken by an intervening command, and short, long and swapped-length frames. These cases separate "acted at chip-select rise" from "acted too early or on a bad count". A long seeded random sequence mixes all opcodes, unknown bytes, wrong lengths, both modes and stray `pe_done` pulses. A bench model predicts the status after every frame, and this exposes ordering faults in the arm one-shot and in the priority between commands.

// File: rtl/spif_cmd_pkg.sv
package spif_cmd_pkg;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_ARM  = 8'h50;
  localparam logic [7:0] OP_SRWR = 8'h01;
  localparam logic [7:0] OP_AAI  = 8'hAF;

  localparam int BIT_WEL = 1;
  localparam int BIT_AAI = 6;
  localparam int BP_LO   = 2;
  localparam int BP_HI   = 5;

  localparam int OP_BITS   = 8;
  localparam int LONG_BITS = 2 * OP_BITS;
  localparam int CNT_W     = $clog2(LONG_BITS + 1) + 1;

  typedef struct packed {
    logic [OP_BITS-1:0] op;
    logic [OP_BITS-1:0] data;
    logic [CNT_W-1:0]   nbits;
  } frame_t;
endpackage

// File: rtl/spif_sync.sv
module spif_sync #(
  parameter int          W       = 3,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [W-1:0] stage_d;
    if (s == 0) begin : g_first
      assign stage_d = d_i;
    end else begin : g_rest
      assign stage_d = stage_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= RST_VAL;
      else        stage_q[s] <= stage_d;
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/spif_frame_rx.sv
module spif_frame_rx
  import spif_cmd_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   sck_s,
  input  logic   cs_n_s,
  input  logic   si_s,
  output logic   frame_done,
  output frame_t frame
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic                 sck_d_q, sck_d_n;
  logic                 cs_d_q,  cs_d_n;
  logic [LONG_BITS-1:0] sh_q,    sh_n;
  logic [CNT_W-1:0]     cnt_q,   cnt_n;
  logic                 sck_rise, cs_rise;

  assign sck_rise = sck_s & ~sck_d_q & ~cs_n_s;
  assign cs_rise  = cs_n_s & ~cs_d_q;

  always_comb begin
    sck_d_n = sck_s;
    cs_d_n  = cs_n_s;
    sh_n    = sh_q;
    cnt_n   = cnt_q;
    if (cs_n_s) begin
      cnt_n = '0;
    end else if (sck_rise) begin
      sh_n = {sh_q[LONG_BITS-2:0], si_s};
      if (cnt_q != CNT_MAX) cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d_q <= 1'b0;
      cs_d_q  <= 1'b1;
      sh_q    <= '0;
      cnt_q   <= '0;
    end else begin
      sck_d_q <= sck_d_n;
      cs_d_q  <= cs_d_n;
      sh_q    <= sh_n;
      cnt_q   <= cnt_n;
    end
  end

  always_comb begin
    frame_done  = cs_rise;
    frame.nbits = cnt_q;
    frame.data  = sh_q[OP_BITS-1:0];
    if (cnt_q == CNT_W'(LONG_BITS)) frame.op = sh_q[LONG_BITS-1:OP_BITS];
    else                            frame.op = sh_q[OP_BITS-1:0];
  end

  // R4: the count restarts whenever chip-select is high
  p_cnt_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_s |=> (cnt_q == '0));
  // R7: each rising serial clock inside a frame adds one bit
  p_cnt_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_rise && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/spif_cmd_exec.sv
module spif_cmd_exec
  import spif_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_done,
  input  frame_t     frame,
  input  logic       pe_done,
  output logic       wr_grant,
  output logic [7:0] status
);
  logic                 wel_q, wel_n;
  logic                 aai_q, aai_n;
  logic                 arm_q, arm_n;
  logic [BP_HI:BP_LO]   bp_q,  bp_n;
  logic                 len_ok, valid;
  logic                 is_srwr;

  assign is_srwr = (frame.op == OP_SRWR);
  assign len_ok  = is_srwr ? (frame.nbits == CNT_W'(LONG_BITS))
                           : (frame.nbits == CNT_W'(OP_BITS));
  assign valid   = frame_done & len_ok;

  always_comb begin
    wel_n = wel_q;
    aai_n = aai_q;
    arm_n = arm_q;
    bp_n  = bp_q;
    if (valid) begin
      arm_n = (frame.op == OP_ARM);
      unique case (frame.op)
        OP_WREN: wel_n = 1'b1;
        OP_WRDI: begin
          wel_n = 1'b0;
          aai_n = 1'b0;
        end
        OP_AAI:  if (wel_q) aai_n = 1'b1;
        OP_SRWR: if (arm_q) begin
          bp_n  = frame.data[BP_HI:BP_LO];
          wel_n = 1'b0;
        end
        default: ;
      endcase
    end
    if (pe_done) wel_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel_q <= 1'b0;
      aai_q <= 1'b0;
      arm_q <= 1'b0;
      bp_q  <= '0;
    end else begin
      wel_q <= wel_n;
      aai_q <= aai_n;
      arm_q <= arm_n;
      bp_q  <= bp_n;
    end
  end

  always_comb begin
    status          = '0;
    status[BIT_WEL] = wel_q;
    status[BIT_AAI] = aai_q;
    status[BP_HI:BP_LO] = bp_q;
  end
  assign wr_grant = wel_q;

  // R1
  p_wren_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && frame.op == OP_WREN && !pe_done) |=> wr_grant);
  // R2
  p_wrdi_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && frame.op == OP_WRDI) |=> (!status[BIT_WEL] && !status[BIT_AAI]));
  // R3
  p_pe_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pe_done |=> !wr_grant);
  // R4
  p_bad_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !len_ok && !pe_done) |=> ($stable(status) && $stable(arm_q)));
  // R5
  p_srwr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && is_srwr && arm_q) |=>
      (status[BP_HI:BP_LO] == $past(frame.data[BP_HI:BP_LO]) && !wr_grant));
  // R6
  p_arm_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_q && valid && frame.op != OP_ARM) |=> !arm_q);
  // R9
  p_aai_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && frame.op == OP_AAI && !wel_q) |=> (status[BIT_AAI] == $past(status[BIT_AAI])));
endmodule

// File: rtl/spif_wr_ctrl.sv
module spif_wr_ctrl
  import spif_cmd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       spi_sck,
  input  logic       spi_cs_n,
  input  logic       spi_si,
  output logic       spi_so,
  output logic       spi_so_oe,
  input  logic       pe_done,
  output logic       wr_grant,
  output logic [7:0] status
);
  logic [2:0] pins_s;
  logic       frame_done;
  frame_t     frame;

  spif_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({spi_sck, spi_cs_n, spi_si}),
    .q_o   (pins_s)
  );

  spif_frame_rx u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .sck_s      (pins_s[2]),
    .cs_n_s     (pins_s[1]),
    .si_s       (pins_s[0]),
    .frame_done (frame_done),
    .frame      (frame)
  );

  spif_cmd_exec u_exec (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_done (frame_done),
    .frame      (frame),
    .pe_done    (pe_done),
    .wr_grant   (wr_grant),
    .status     (status)
  );

  assign spi_so    = 1'b0;
  assign spi_so_oe = 1'b0;
endmodule

// File: tb/test_spif_wr_ctrl.sv
module test_spif_wr_ctrl;
  localparam time TCK  = 8ns;
  localparam int  HALF = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_sck = 1'b0, spi_cs_n = 1'b1, spi_si = 1'b0, pe_done = 1'b0;
  logic spi_so, spi_so_oe, wr_grant;
  logic [7:0] status;

  int checks = 0, errors = 0;
  bit finished = 0;

  bit e_wel, e_aai, e_arm;
  logic [3:0] e_bp;

  always #(TCK/2) clk = ~clk;

  spif_wr_ctrl i_spif_wr_ctrl (
    .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_si(spi_si), .spi_so(spi_so), .spi_so_oe(spi_so_oe),
    .pe_done(pe_done), .wr_grant(wr_grant), .status(status)
  );

  function automatic logic [7:0] exp_status();
    return {1'b0, e_aai, e_bp, e_wel, 1'b0};
  endfunction

  // model of one frame at chip-select rise
  function automatic void model_frame(logic [15:0] w, int nbits);
    logic [7:0] op = w[15:8];
    bit ok = (op == 8'h01) ? (nbits == 16) : (nbits == 8);
    bit was_arm = e_arm;
    if (!ok) return;
    e_arm = (op == 8'h50);
    case (op)
      8'h06: e_wel = 1;
      8'h04: begin e_wel = 0; e_aai = 0; end
      8'hAF: if (e_wel) e_aai = 1;
      8'h01: if (was_arm) begin e_bp = w[5:2]; e_wel = 0; end
      default: ;
    endcase
  endfunction

  function automatic string tag_of(logic [15:0] w, int nbits);
    logic [7:0] op = w[15:8];
    if (((op == 8'h01) ? 16 : 8) != nbits) return "R4";
    case (op)
      8'h06: return "R1";
      8'h04: return "R2";
      8'h50: return "R6";
      8'h01: return "R5";
      8'hAF: return "R9";
      default: return "R6";
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(logic [15:0] w, int nbits, bit mode3);
    @(negedge clk);
    spi_sck = mode3;
    wait_clk(2);
    spi_cs_n = 0;
    wait_clk(HALF);
    for (int i = 0; i < nbits; i++) begin
      if (mode3) spi_sck = 0;
      spi_si = w[15-i];
      wait_clk(HALF);
      spi_sck = 1;
      wait_clk(HALF);
      if (!mode3) spi_sck = 0;
      if (i == nbits / 2) check("R8", spi_so_oe, 1'b0);
    end
    wait_clk(HALF);
    spi_cs_n = 1;
    model_frame(w, nbits);
    wait_clk(8);
  endtask

  task automatic pulse_pe();
    @(negedge clk);
    pe_done = 1;
    @(negedge clk);
    pe_done = 0;
    e_wel = 0;
    check("R3", wr_grant, 1'b0);
  endtask

  task automatic chk_state(string req);
    check(req, status, exp_status());
    check("R3", wr_grant, e_wel);
  endtask

  initial begin
    #(TCK * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    e_wel = 0; e_aai = 0; e_arm = 0; e_bp = 0;
    wait_clk(4);
    rst_n = 1;
    wait_clk(4);
    check("R10", status, 8'h00);
    check("R10", wr_grant, 1'b0);

    // R9 auto-increment refused without permission
    send(16'hAF00, 8, 0);  chk_state("R9");
    // R1 in mode 0 and mode 3
    send(16'h0600, 8, 0);  chk_state("R1");
    check("R1", status[1], 1'b1);
    send(16'h0400, 8, 1);  chk_state("R2");
    send(16'h0600, 8, 1);  chk_state("R7");
    send(16'hAF00, 8, 0);  chk_state("R9");
    check("R9", status[6], 1'b1);
    // R2 clears both bits
    send(16'h0400, 8, 0);  chk_state("R2");
    check("R2", status & 8'h42, 8'h00);
    // R4 short and long frames ignored
    send(16'h0600, 7, 0);  chk_state("R4");
    send(16'h0600, 9, 1);  chk_state("R4");
    check("R4", wr_grant, 1'b0);
    // R5 arm then status write
    send(16'h0600, 8, 0);
    send(16'h5000, 8, 0);
    send(16'h01FF, 16, 1); chk_state("R5");
    check("R5", status, 8'h3C);
    // R6 arm broken by another command
    send(16'h5000, 8, 1);
    send(16'h0600, 8, 0);
    send(16'h0100, 16, 0); chk_state("R6");
    check("R6", status[5:2], 4'hF);
    // R6 unarmed status write ignored
    send(16'h0100, 16, 1); chk_state("R6");
    // R4 bad-length frame keeps arm intact
    send(16'h5000, 8, 0);
    send(16'h0400, 9, 0);
    send(16'h0124, 16, 0); chk_state("R4");
    check("R4", status[5:2], 4'h9);
    // R3 engine completion drops grant
    send(16'h0600, 8, 1);
    pulse_pe();            chk_state("R3");
    // R7 MSB-first: reversed opcode 0x60 must not act as 0x06
    send(16'h6000, 8, 0);  chk_state("R7");
    check("R7", wr_grant, 1'b0);

    for (int n = 0; n < 160; n++) begin
      logic [15:0] w;
      int nb;
      int pick = $urandom_range(0, 9);
      int lsel = $urandom_range(0, 9);
      case (pick)
        0, 1, 2: w[15:8] = 8'h06;
        3:       w[15:8] = 8'h04;
        4, 5:    w[15:8] = 8'h50;
        6, 7:    w[15:8] = 8'h01;
        8:       w[15:8] = 8'hAF;
        default: w[15:8] = 8'($urandom);
      endcase
      w[7:0] = 8'($urandom);
      nb = (w[15:8] == 8'h01) ? 16 : 8;
      if (lsel == 7) nb = nb - 1;
      else if (lsel == 8) nb = nb + 1;
      else if (lsel == 9) nb = (nb == 16) ? 8 : 16;
      send(w, nb, bit'($urandom_range(0, 1)));
      chk_state(tag_of(w, nb));
      if ($urandom_range(0, 7) == 0) pulse_pe();
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule